// File: doc/BRIEF.md
# Period and Pulse-Width Measurement Timer

This block is a 16-bit down-counter for an external input pin. It can measure the period of a signal, measure the width of each high phase and each low phase one after another, or count events on the pin. A free-running prescaler produces a count pulse once every `DIV` clock cycles. The counter steps down on that pulse, or on pin edges in event mode. When it steps past zero it reloads from a reload register and raises a one-cycle timer interrupt.

The pin passes through a flop synchroniser and then an edge detector. Each edge that the current mode selects raises a one-cycle edge interrupt. In the two measurement modes that edge also copies the running count into a capture register and restarts the counter from the reload value. Software reads the elapsed time as the reload value minus the captured count.

Software uses a byte-wide register port. The 16-bit reload value is written low byte first. The counter and the capture register are read high byte first. Reading a high byte freezes the matching low byte, so the two halves belong to the same instant.

Top module: `cmt_timer`

## Requirements
- R1: After reset the counter, the reload value and the capture register are 0. The control register at address 2 reads 0x08, so the counter is stopped. Both interrupt outputs are low.
- R2: In timer mode (control bits [1:0] = 00) with the stop bit clear, the counter steps down by one on each prescaler pulse. The first pulse comes on the `DIV`-th rising clock edge after reset, and one follows every `DIV` edges after that. A pulse that finds the count at 0 loads the reload value instead and drives `irq_tmr` high for one cycle. With reload value N, timer pulses are therefore (N+1)*`DIV` cycles apart.
- R3: While the stop bit (control bit 3) is set, the counter holds its value in every mode. Pin edges still raise `irq_cntr`.
- R4: A write to address 0 only stages the low reload byte. A write to address 1 sets the reload value to {written byte, staged byte}. If the counter is stopped, that write also loads the same value into the counter.
- R5: A read of address 1 returns counter bits [15:8] in the same cycle and freezes counter bits [7:0]. A read of address 4 does the same for the capture register. Addresses 0 and 3 return the frozen byte, so later counting does not change the value read.
- R6: In period mode (bits [1:0] = 01), each edge of the selected polarity copies the count into the capture register and reloads the counter. Bit 2 picks the polarity: 0 for rising, 1 for falling. Edges of the other polarity do nothing. With pin edges P cycles apart, P a multiple of `DIV`, the capture reads reload - P/`DIV`.
- R7: In continuous mode (bits [1:0] = 11), both rising and falling edges capture and reload. After a falling edge the capture reads reload - (high time)/`DIV`. After a rising edge it reads reload - (low time)/`DIV`.
- R8: In event mode (bits [1:0] = 10), the counter steps down on each pin edge of the selected polarity and ignores the prescaler. It reloads and pulses `irq_tmr` when an edge finds the count at 0.
- R9: `irq_cntr` pulses for one cycle for each selected pin edge. That means both polarities in continuous mode and the bit-2 polarity in the other modes.
- R10: A pin change driven between clock edges k and k+1 takes effect on rising edge k+3. That edge is when `irq_cntr` rises and when any capture, reload or event step happens.
- R11: In timer and event modes the capture register never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cntr_pin | input | 1 | External measured input, asynchronous |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, triggers the low-byte freeze on high-byte addresses |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_tmr | output | 1 | One-cycle pulse when the counter steps past zero |
| irq_cntr | output | 1 | One-cycle pulse on each selected pin edge |

## Verification
Read data is due in the same cycle as the address. Register writes take effect on the next clock edge. Pin changes act on the third edge after the change, and prescaler pulses act on every edge whose count from reset is a multiple of `DIV`. The bench keeps its own count of clock edges since reset and changes the pin only at one fixed prescaler phase, with every high and low time a multiple of `DIV`, so every expected count and capture works out exactly. It samples outputs at falling edges, counts interrupt pulses and their spacing there, and checks the edge interrupt on each of the cycles around the third edge.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_TIMER  = 2'b00,
    MODE_PERIOD = 2'b01,
    MODE_EVENT  = 2'b10,
    MODE_PULSE  = 2'b11
  } mode_e;

  // control register layout: [3] stop, [2] falling-edge select, [1:0] mode
  typedef struct packed {
    logic  stop;
    logic  fall_sel;
    mode_e mode;
  } ctrl_t;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd4;
endpackage

// File: rtl/cmt_prescaler.sv
`timescale 1ns/1ps
module cmt_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q, div_d;

  assign tick = (div_q == LAST);

  always_comb begin
    if (tick) div_d = '0;
    else      div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/cmt_edge_sync.sv
`timescale 1ns/1ps
module cmt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic synced;
  logic prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic d;
    logic q;
    if (i == 0) begin : g_first
      assign d = pin;
    end else begin : g_next
      assign d = g_stage[i-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end
  end

  assign synced = g_stage[STAGES-1].q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;
  end

  assign rise = synced & ~prev_q;
  assign fall = ~synced & prev_q;
endmodule

// File: rtl/cmt_regs.sv
`timescale 1ns/1ps
module cmt_regs
  import cmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  capture,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  latch,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  load_val
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] stage_q, stage_d;
  logic [CNT_W-1:0]  latch_q, latch_d;
  logic [BYTE_W-1:0] snap_q, snap_d;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[BYTE_W-1:4];

  always_comb begin
    ctrl_d  = ctrl_q;
    stage_d = stage_q;
    latch_d = latch_q;
    snap_d  = snap_q;
    if (bus_wr) begin
      case (bus_addr)
        A_CNT_LO: stage_d = bus_wdata;
        A_CNT_HI: latch_d = {bus_wdata, stage_q};
        A_CTRL:   ctrl_d  = ctrl_t'(bus_wdata[3:0]);
        default:  ;
      endcase
    end
    if (bus_rd) begin
      case (bus_addr)
        A_CNT_HI: snap_d = count[BYTE_W-1:0];
        A_CAP_HI: snap_d = capture[BYTE_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '{stop: 1'b1, fall_sel: 1'b0, mode: MODE_TIMER};
      stage_q <= '0;
      latch_q <= '0;
      snap_q  <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      stage_q <= stage_d;
      latch_q <= latch_d;
      snap_q  <= snap_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CNT_LO: bus_rdata = snap_q;
      A_CNT_HI: bus_rdata = count[CNT_W-1:BYTE_W];
      A_CTRL:   bus_rdata = {4'b0000, ctrl_q};
      A_CAP_LO: bus_rdata = snap_q;
      A_CAP_HI: bus_rdata = capture[CNT_W-1:BYTE_W];
      default:  bus_rdata = '0;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign latch    = latch_q;
  assign cnt_load = bus_wr && (bus_addr == A_CNT_HI) && ctrl_q.stop;
  assign load_val = {bus_wdata, stage_q};
endmodule

// File: rtl/cmt_core.sv
`timescale 1ns/1ps
module cmt_core
  import cmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rise,
  input  logic             fall,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] latch,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic             irq_tmr,
  output logic             irq_cntr
);
  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             tmr_q, tmr_d;
  logic             edg_q, edg_d;
  logic             sel_edge;
  logic             measuring;
  logic             step;

  always_comb begin
    if (ctrl.mode == MODE_PULSE) sel_edge = rise | fall;
    else if (ctrl.fall_sel)      sel_edge = fall;
    else                         sel_edge = rise;
  end

  assign measuring = (ctrl.mode == MODE_PERIOD) || (ctrl.mode == MODE_PULSE);
  assign step      = (ctrl.mode == MODE_EVENT) ? sel_edge : tick;

  always_comb begin
    count_d = count_q;
    cap_d   = cap_q;
    tmr_d   = 1'b0;
    edg_d   = sel_edge;
    if (cnt_load) begin
      count_d = load_val;
    end else if (!ctrl.stop) begin
      if (measuring && sel_edge) begin
        cap_d   = count_q;
        count_d = latch;
      end else if (step) begin
        if (count_q == '0) begin
          count_d = latch;
          tmr_d   = 1'b1;
        end else begin
          count_d = count_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      cap_q   <= '0;
      tmr_q   <= 1'b0;
      edg_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      cap_q   <= cap_d;
      tmr_q   <= tmr_d;
      edg_q   <= edg_d;
    end
  end

  assign count    = count_q;
  assign capture  = cap_q;
  assign irq_tmr  = tmr_q;
  assign irq_cntr = edg_q;
endmodule

// File: rtl/cmt_timer.sv
`timescale 1ns/1ps
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int DIV         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cntr_pin,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq_tmr,
  output logic              irq_cntr
);
  logic             tick;
  logic             rise;
  logic             fall;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] latch;
  logic             cnt_load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] capture;

  cmt_prescaler #(.DIV(DIV)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  cmt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (cntr_pin),
    .rise (rise),
    .fall (fall)
  );

  cmt_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .count    (count),
    .capture  (capture),
    .ctrl     (ctrl),
    .latch    (latch),
    .cnt_load (cnt_load),
    .load_val (load_val)
  );

  cmt_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .rise    (rise),
    .fall    (fall),
    .ctrl    (ctrl),
    .latch   (latch),
    .cnt_load(cnt_load),
    .load_val(load_val),
    .count   (count),
    .capture (capture),
    .irq_tmr (irq_tmr),
    .irq_cntr(irq_cntr)
  );
endmodule

// File: rtl/cmt_timer_chk.sv
`timescale 1ns/1ps
module cmt_timer_chk
  import cmt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              irq_tmr,
  input logic              irq_cntr,
  input ctrl_t             ctrl,
  input logic              cnt_load,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  latch,
  input logic [CNT_W-1:0]  capture,
  input logic              rise,
  input logic              fall
);
  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.stop && !cnt_load) |=> $stable(count));

  // R2
  underflow_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tmr |-> ($past(count) == '0));

  // R2
  underflow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tmr |-> (count == $past(latch)));

  // R11
  capture_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(capture) |-> ($past(ctrl.mode) == MODE_PERIOD || $past(ctrl.mode) == MODE_PULSE));

  // R9
  edge_irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cntr |-> $past(rise || fall));

  // R6
  edge_irq_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cntr && $past(ctrl.mode) != MODE_PULSE && !$past(ctrl.fall_sel)) |-> $past(rise));

  // R5
  low_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_rd && bus_addr == A_CNT_HI) && bus_addr == A_CNT_LO)
      |-> (bus_rdata == $past(count[BYTE_W-1:0])));
endmodule

bind cmt_timer cmt_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .bus_rdata(bus_rdata),
  .irq_tmr  (irq_tmr),
  .irq_cntr (irq_cntr),
  .ctrl     (ctrl),
  .cnt_load (cnt_load),
  .count    (count),
  .latch    (latch),
  .capture  (capture),
  .rise     (rise),
  .fall     (fall)
);

// File: tb/cmt_timer_test.sv
`timescale 1ns/1ps
module cmt_timer_test;
  localparam int D = 4;

  logic       clk;
  logic       rst_n;
  logic       pin;
  logic [2:0] addr;
  logic       wr;
  logic       rd;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq_tmr;
  logic       irq_cntr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int n_tmr  = 0;
  int n_edg  = 0;
  int last_t = 0;
  int prev_t = 0;
  int wr_edge = 0;

  cmt_timer #(.DIV(D), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .cntr_pin(pin), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_tmr(irq_tmr), .irq_cntr(irq_cntr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n && irq_tmr) begin
      n_tmr  <= n_tmr + 1;
      prev_t <= last_t;
      last_t <= cyc;
    end
    if (rst_n && irq_cntr) n_edg <= n_edg + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr8(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    wr_edge = cyc + 1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd8(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd = 1'b0;
    #1 v = rdata;
  endtask

  task automatic rd16(input logic [2:0] ahi, input logic [2:0] alo, output logic [15:0] v);
    @(negedge clk);
    addr = ahi; rd = 1'b1;
    #1 v[15:8] = rdata;
    @(negedge clk);
    addr = alo; rd = 1'b0;
    #1 v[7:0] = rdata;
  endtask

  task automatic align;
    @(negedge clk);
    while (cyc % D != 2) @(negedge clk);
  endtask

  // holds the pin at val for len cycles, starting at the next negedge
  task automatic drive(input logic val, input int len);
    @(negedge clk);
    pin = val;
    repeat (len - 1) @(negedge clk);
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, hi);
      drive(1'b0, lo);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    logic [15:0] cap_keep;
    int          a_run;
    int          ticks;
    int          e0;
    int          t0;
    int          m;

    pin = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd8(3'd2, b);              chk("R1 ctrl", b, 8'h08);
    rd16(3'd1, 3'd0, v);       chk("R1 count", v, 0);
    rd16(3'd4, 3'd3, v);       chk("R1 capture", v, 0);
    chk("R1 irq_tmr", irq_tmr, 0);
    chk("R1 irq_cntr", irq_cntr, 0);

    // R4 staging and commit while stopped
    wr8(3'd0, 8'h55);
    rd16(3'd1, 3'd0, v);       chk("R4 low write alone", v, 0);
    wr8(3'd1, 8'h12);
    rd16(3'd1, 3'd0, v);       chk("R4 high write loads", v, 16'h1255);

    // R3 stopped counter holds
    repeat (50) @(negedge clk);
    rd16(3'd1, 3'd0, v);       chk("R3 stopped hold", v, 16'h1255);

    // R5 snapshot, R2 exact count over a run window
    @(negedge clk); addr = 3'd1; rd = 1'b1;
    #1 b = rdata;              chk("R5 high byte", b, 8'h12);
    @(negedge clk); rd = 1'b0;
    wr8(3'd2, 8'h00);
    a_run = wr_edge;
    repeat (40) @(negedge clk);
    rd8(3'd0, b);              chk("R5 frozen low byte", b, 8'h55);
    wr8(3'd2, 8'h08);
    ticks = 0;
    for (int k = a_run + 1; k <= wr_edge; k++) if (k % D == 0) ticks++;
    rd16(3'd1, 3'd0, v);       chk("R2 prescaled count", v, 16'h1255 - ticks);

    // R2 underflow spacing
    wr8(3'd0, 8'h03);
    wr8(3'd1, 8'h00);
    t0 = n_tmr;
    wr8(3'd2, 8'h00);
    repeat (70) @(negedge clk);
    chk("R2 underflow interval", last_t - prev_t, (3 + 1) * D);
    chk("R2 underflow pulses seen", (n_tmr - t0 >= 3) ? 1 : 0, 1);
    wr8(3'd2, 8'h08);
    rd16(3'd4, 3'd3, v);       chk("R11 capture held in timer mode", v, 0);

    // R6 period mode, rising edges, with R10 latency
    wr8(3'd0, 8'd100);
    wr8(3'd1, 8'd0);
    wr8(3'd2, 8'h01);
    e0 = n_edg;
    align();
    @(negedge clk); pin = 1'b1; m = cyc;
    @(negedge clk); chk("R10 no irq at k+1", irq_cntr, 0);
    @(negedge clk); chk("R10 no irq at k+2", irq_cntr, 0);
    @(negedge clk); chk("R10 irq at k+3", irq_cntr, 1);
    chk("R10 edge cycle", cyc - m, 3);
    @(negedge clk); chk("R10 irq one cycle", irq_cntr, 0);
    repeat (12 - 5) @(negedge clk);
    drive(1'b0, 20);
    pulses(3, 12, 20);
    rd16(3'd4, 3'd3, v);       chk("R6 rising period capture", v, 100 - 32 / D);
    chk("R9 rising edge count", n_edg - e0, 4);

    // R6 falling polarity
    wr8(3'd2, 8'h05);
    e0 = n_edg;
    align();
    pulses(3, 8, 24);
    rd16(3'd4, 3'd3, v);       chk("R6 falling period capture", v, 100 - 32 / D);
    chk("R9 falling edge count", n_edg - e0, 3);

    // R7 continuous high/low measurement
    wr8(3'd2, 8'h03);
    e0 = n_edg;
    align();
    pulses(2, 12, 20);
    drive(1'b1, 6);
    rd16(3'd4, 3'd3, v);       chk("R7 low phase capture", v, 100 - 20 / D);
    repeat (12 - 8) @(negedge clk);
    drive(1'b0, 20);
    rd16(3'd4, 3'd3, v);       chk("R7 high phase capture", v, 100 - 12 / D);
    chk("R9 both edges count", n_edg - e0, 6);
    cap_keep = v;

    // R8 event counter
    wr8(3'd2, 8'h0A);
    wr8(3'd0, 8'd10);
    wr8(3'd1, 8'd0);
    wr8(3'd2, 8'h02);
    pulses(3, 8, 8);
    rd16(3'd1, 3'd0, v);       chk("R8 rising events", v, 7);
    repeat (100) @(negedge clk);
    rd16(3'd1, 3'd0, v);       chk("R8 prescaler ignored", v, 7);
    wr8(3'd2, 8'h06);
    pulses(2, 8, 8);
    rd16(3'd1, 3'd0, v);       chk("R8 falling events", v, 5);
    t0 = n_tmr;
    pulses(6, 8, 8);
    rd16(3'd1, 3'd0, v);       chk("R8 event reload", v, 10);
    chk("R8 event underflow irq", n_tmr - t0, 1);
    rd16(3'd4, 3'd3, v);       chk("R11 capture held in event mode", v, cap_keep);

    // R3 stop in event mode, edges still flagged
    wr8(3'd2, 8'h0E);
    e0 = n_edg;
    pulses(2, 8, 8);
    rd16(3'd1, 3'd0, v);       chk("R3 stopped events ignored", v, 10);
    chk("R9 edges flagged while stopped", n_edg - e0, 2);

    finish_run();
  end
endmodule